// File: doc/BRIEF.md
# Multiprocessor-Bit Asynchronous Serial Transmitter

This block sends bytes on one asynchronous serial line. Each frame carries an extra address/data marker bit, called the multiprocessor bit, that software picks. Software works through four small registers on a single-cycle write bus with a combinational read path. It checks that the holding register is free and writes a byte. It sets the marker value and then clears the empty flag to hand the byte over. When the serializer is idle it takes the byte at once. When a frame is in flight, it takes the byte when the stop bit ends, so frames go back to back.

When transmission is enabled, the line first stays high for one whole frame time before any data frame may start. A transmit-end flag tells software when the last frame has fully left the line. An interrupt request follows the empty flag when its enable is set. A port override can drive the pin from a register bit instead of the serializer, which lets software hold a break (steady low) after it switches the transmitter off.

The register bus has no back-pressure: every write completes in the cycle it is strobed. The only flow control is the empty flag. Bit timing comes from an external `baud_tick` strobe, and each bit lasts a fixed number of strobes.

Top module: `mp_serial_tx`

## Requirements
- R1: After reset, the status register reads empty=1, done=1 and marker=0. `txd` is 1 and `tx_irq` is 0.
- R2: The register map is as follows. Address 0 holds the data byte. Address 1 holds status: bit0 is empty (writing 0 clears it, writing 1 has no effect), bit1 is done (read-only) and bit2 is the marker bit (read/write). Address 2 holds control: bit0 is transmit enable and bit1 is interrupt enable. Address 3 holds the port: bit0 is the pin level and bit1 is the override. A data write while empty=0 is ignored, and the old byte reads back.
- R3: A frame is a 0 start bit, then 8 data bits LSB first, then the marker bit, then a 1 stop bit. Each bit lasts 16 baud ticks.
- R4: After transmit enable goes from 0 to 1, the line stays 1 for at least 11×16 ticks before the first start bit, even when a byte is already waiting.
- R5: When the serializer is idle, enabled and empty=0, the byte moves into the shifter. Empty becomes 1 and done becomes 0.
- R6: If a byte is pending when a stop bit ends, the next start bit follows at once. Frames then start exactly 176 ticks apart.
- R7: If the stop bit ends while empty=1, done becomes 1 and the line stays 1.
- R8: `tx_irq` is 1 exactly when empty=1 and the interrupt enable is 1.
- R9: Clearing transmit enable forces the serializer output to 1 and aborts any frame in progress. On the next cycle empty and done both read 1.
- R10: If software clears empty in the same cycle that the hardware sets it on a transfer, empty ends at 1, and the byte is sent only once.
- R11: While the override bit is 1, `txd` equals the port level bit, whatever the transmitter is doing and whether or not it is enabled.
- R12: Bit timing counts baud ticks, not clocks. With one tick every third clock, frames keep the R3 format and take three times as long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle strobe; 16 strobes per bit |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 2 | Register address for reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| txd | output | 1 | Serial line, or the port level under override |
| tx_irq | output | 1 | Data-empty interrupt request |

## Verification
The properties assume three things about the inputs. Each bus write is a one-cycle strobe, and its address and data are valid in that cycle. Transmit enable changes only through a control-register write. `baud_tick` is a plain strobe with no other meaning. The bench drives the bus only from write and read tasks that place each access between falling edges. It generates ticks as periodic single-cycle pulses at a fixed divisor. The one deliberate collision is two back-to-back empty-clearing writes, which make the software clear land on the cycle of a hardware transfer.

// File: rtl/mptx_pkg.sv
package mptx_pkg;
  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam logic [1:0] ADDR_PORT = 2'd3;

  localparam int ST_EMPTY = 0;
  localparam int ST_DONE  = 1;
  localparam int ST_MARK  = 2;
  localparam int CT_EN    = 0;
  localparam int CT_IRQ   = 1;
  localparam int PT_LVL   = 0;
  localparam int PT_OVR   = 1;

  typedef enum logic [1:0] {
    SH_IDLE = 2'd0,
    SH_MARK = 2'd1,
    SH_SEND = 2'd2
  } sh_state_e;
endpackage

// File: rtl/mptx_regs.sv
module mptx_regs
  import mptx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              load_ack,
  input  logic              done_set,
  output logic              tx_en,
  output logic              en_rise,
  output logic              empty,
  output logic              done,
  output logic              mark_bit,
  output logic [DATA_W-1:0] tx_data,
  output logic              port_ovr,
  output logic              port_lvl,
  output logic              tx_irq
);
  logic irq_en, en_q, en_fall;
  logic wr_data, wr_stat, wr_ctrl, wr_port;

  assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
  assign wr_stat = bus_wr && (bus_addr == ADDR_STAT);
  assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_port = bus_wr && (bus_addr == ADDR_PORT);

  assign en_rise = tx_en && !en_q;
  assign en_fall = en_q && !tx_en;
  assign tx_irq  = empty && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en    <= 1'b0;
      en_q     <= 1'b0;
      irq_en   <= 1'b0;
      empty    <= 1'b1;
      done     <= 1'b1;
      mark_bit <= 1'b0;
      tx_data  <= '0;
      port_ovr <= 1'b0;
      port_lvl <= 1'b0;
    end else begin
      en_q <= tx_en;
      if (wr_ctrl) begin
        tx_en  <= bus_wdata[CT_EN];
        irq_en <= bus_wdata[CT_IRQ];
      end
      if (wr_port) begin
        port_ovr <= bus_wdata[PT_OVR];
        port_lvl <= bus_wdata[PT_LVL];
      end
      if (wr_data && empty) tx_data <= bus_wdata;
      if (wr_stat) mark_bit <= bus_wdata[ST_MARK];
      // hardware set outranks a software clear in the same cycle
      if (en_fall || load_ack) empty <= 1'b1;
      else if (wr_stat && !bus_wdata[ST_EMPTY]) empty <= 1'b0;
      if (en_fall) done <= 1'b1;
      else if (load_ack) done <= 1'b0;
      else if (done_set) done <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      ADDR_DATA: bus_rdata = tx_data;
      ADDR_STAT: begin
        bus_rdata[ST_EMPTY] = empty;
        bus_rdata[ST_DONE]  = done;
        bus_rdata[ST_MARK]  = mark_bit;
      end
      ADDR_CTRL: begin
        bus_rdata[CT_EN]  = tx_en;
        bus_rdata[CT_IRQ] = irq_en;
      end
      default: begin
        bus_rdata[PT_LVL] = port_lvl;
        bus_rdata[PT_OVR] = port_ovr;
      end
    endcase
  end
endmodule

// File: rtl/mptx_shifter.sv
module mptx_shifter
  import mptx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              tx_en,
  input  logic              en_rise,
  input  logic              pending,
  input  logic              mark_bit,
  input  logic [DATA_W-1:0] tx_data,
  output logic              load_ack,
  output logic              done_set,
  output logic              in_mark,
  output logic              line
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int TCW     = $clog2(OVS);
  localparam int BCW     = $clog2(FRAME_W);

  sh_state_e          state;
  logic [TCW-1:0]     tick_cnt;
  logic [BCW-1:0]     bit_idx;
  logic [FRAME_W-1:0] shreg;
  logic               bit_end, last_bit, frame_end;

  assign bit_end   = baud_tick && (tick_cnt == TCW'(OVS - 1));
  assign last_bit  = (bit_idx == BCW'(FRAME_W - 1));
  assign frame_end = (state == SH_SEND) && bit_end && last_bit;
  assign load_ack  = tx_en && !en_rise && pending &&
                     ((state == SH_IDLE) || frame_end);
  assign done_set  = tx_en && frame_end && !pending;
  assign in_mark   = (state == SH_MARK);
  assign line      = (tx_en && (state == SH_SEND)) ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SH_IDLE;
      tick_cnt <= '0;
      bit_idx  <= '0;
      shreg    <= '1;
    end else if (!tx_en) begin
      state    <= SH_IDLE;
      tick_cnt <= '0;
      bit_idx  <= '0;
      shreg    <= '1;
    end else if (en_rise) begin
      state    <= SH_MARK;
      tick_cnt <= '0;
      bit_idx  <= '0;
    end else if (load_ack) begin
      state    <= SH_SEND;
      tick_cnt <= '0;
      bit_idx  <= '0;
      shreg    <= {1'b1, mark_bit, tx_data, 1'b0};
    end else begin
      if (baud_tick && state != SH_IDLE)
        tick_cnt <= bit_end ? '0 : tick_cnt + 1'b1;
      if (bit_end && state != SH_IDLE) begin
        if (last_bit) begin
          state   <= SH_IDLE;
          bit_idx <= '0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          shreg   <= {1'b1, shreg[FRAME_W-1:1]};
        end
      end
    end
  end
endmodule

// File: rtl/mptx_pinmux.sv
module mptx_pinmux (
  input  logic line,
  input  logic port_ovr,
  input  logic port_lvl,
  output logic txd
);
  assign txd = port_ovr ? port_lvl : line;
endmodule

// File: rtl/mp_serial_tx.sv
module mp_serial_tx
  import mptx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              txd,
  output logic              tx_irq
);
  logic              load_ack, done_set, in_mark, line;
  logic              tx_en, en_rise, empty, done, mark_bit;
  logic              port_ovr, port_lvl;
  logic [DATA_W-1:0] tx_data;

  mptx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .load_ack(load_ack),
    .done_set(done_set), .tx_en(tx_en), .en_rise(en_rise), .empty(empty),
    .done(done), .mark_bit(mark_bit), .tx_data(tx_data),
    .port_ovr(port_ovr), .port_lvl(port_lvl), .tx_irq(tx_irq)
  );

  mptx_shifter #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
    .en_rise(en_rise), .pending(!empty), .mark_bit(mark_bit),
    .tx_data(tx_data), .load_ack(load_ack), .done_set(done_set),
    .in_mark(in_mark), .line(line)
  );

  mptx_pinmux u_pin (
    .line(line), .port_ovr(port_ovr), .port_lvl(port_lvl), .txd(txd)
  );
endmodule

// File: rtl/mp_serial_tx_chk.sv
module mp_serial_tx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              tx_en,
  input logic              empty,
  input logic              done,
  input logic              line,
  input logic              load_ack,
  input logic              in_mark,
  input logic [DATA_W-1:0] tx_data
);
  a_r9_flags_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |=> (empty && done));

  a_r9_line_high_off: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> line);

  a_r5_transfer_flags: assert property (@(posedge clk) disable iff (!rst_n)
    load_ack |=> (empty && !done));

  a_r10_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ack && bus_wr && bus_addr == 2'd1 && !bus_wdata[0]) |=> empty);

  a_r4_no_load_marking: assert property (@(posedge clk) disable iff (!rst_n)
    in_mark |-> !load_ack);

  a_r2_data_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd0 && !empty) |=> $stable(tx_data));
endmodule

bind mp_serial_tx mp_serial_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .tx_en(tx_en), .empty(empty), .done(done),
  .line(line), .load_ack(load_ack), .in_mark(in_mark), .tx_data(tx_data)
);

// File: tb/tb_mp_serial_tx.sv
module tb_mp_serial_tx;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       txd, tx_irq;

  int n_tests = 0, n_fail = 0;
  int cyc = 0;
  int tick_div = 1, tphase = 0;
  bit dec_on = 1'b1, chk_period = 1'b0, have_prev = 1'b0, finished = 1'b0;
  int dstate = 0, dcnt = 0, prev_start = 0, first_start = -1, fidx = 0;
  logic [7:0] rx_byte;
  logic rx_mark, rx_bad;
  logic [7:0] exp_data [0:511];
  logic       exp_mark [0:511];
  int exp_n = 0, rx_n = 0;

  mp_serial_tx dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .txd(txd), .tx_irq(tx_irq)
  );

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    n_tests++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // line decoder and tick generator share one process
  always @(negedge clk) begin
    if (!rst_n || !dec_on) begin
      dstate = 0;
    end else if (baud_tick) begin
      if (dstate == 0) begin
        if (txd == 1'b0) begin
          dstate = 1; dcnt = 0; rx_bad = 1'b0;
          if (fidx == 0) first_start = cyc;
          if (chk_period) begin
            if (have_prev) chk("R6 start spacing", cyc - prev_start, 176);
            prev_start = cyc; have_prev = 1'b1;
          end
          fidx++;
        end
      end else begin
        dcnt++;
        if (dcnt % 16 == 8) begin
          int k;
          k = dcnt / 16;
          if (k == 0) begin
            if (txd !== 1'b0) rx_bad = 1'b1;
          end else if (k <= 8) rx_byte[k-1] = txd;
          else if (k == 9) rx_mark = txd;
          else begin
            if (txd !== 1'b1) rx_bad = 1'b1;
            dstate = 0;
            if (rx_n < exp_n) begin
              chk("R3 data byte", rx_byte, exp_data[rx_n]);
              chk("R3 marker bit", rx_mark, exp_mark[rx_n]);
              chk("R3 start/stop", rx_bad, 0);
            end else chk("R10 unexpected frame", rx_n, exp_n - 1);
            rx_n++;
          end
        end
      end
    end
    tphase = tphase + 1;
    if (tphase >= tick_div) tphase = 0;
    baud_tick = (tphase == 0);
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic push(input logic [7:0] d, input logic m);
    exp_data[exp_n] = d; exp_mark[exp_n] = m; exp_n++;
  endtask

  task automatic wait_rx(input int n, input int limit);
    for (int i = 0; i < limit && rx_n < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_P*190000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    int en_cyc, t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd1, s);
    chk("R1 status after reset", s, 8'h03);
    chk("R1 txd after reset", txd, 1);
    chk("R1 irq after reset", tx_irq, 0);

    wr(2'd2, 8'h02);
    @(negedge clk);
    chk("R8 irq with empty and enable", tx_irq, 1);

    wr(2'd0, 8'hA5);
    wr(2'd1, 8'h04);
    @(negedge clk);
    chk("R8 irq after empty cleared", tx_irq, 0);
    wr(2'd0, 8'h3C);
    rd(2'd0, s);
    chk("R2 data write ignored while full", s, 8'hA5);
    rd(2'd1, s);
    chk("R2 status with byte held", s, 8'h06);
    wr(2'd1, 8'h05);
    rd(2'd1, s);
    chk("R2 writing 1 to empty has no effect", s, 8'h06);
    push(8'hA5, 1'b1);

    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h03; en_cyc = cyc;
    @(negedge clk);
    bus_wr = 1'b0;
    repeat (190) @(negedge clk);
    rd(2'd1, s);
    chk("R5 flags after transfer", s, 8'h05);
    wait_rx(1, 400);
    chk_rng("R4 idle frame before first start", first_start - en_cyc, 177, 181);
    repeat (20) @(negedge clk);
    rd(2'd1, s);
    chk("R7 done after last frame", s, 8'h07);
    chk("R7 line high after frame", txd, 1);

    // sweep every byte value back to back
    have_prev = 1'b0; chk_period = 1'b1;
    for (int i = 0; i < 256; i++) begin
      logic [7:0] b;
      logic m;
      b = 8'(i); m = ^b;
      s = 8'h00;
      for (int p = 0; p < 400 && !s[0]; p++) rd(2'd1, s);
      wr(2'd0, b);
      wr(2'd1, {5'd0, m, 2'b00});
      push(b, m);
    end
    wait_rx(exp_n, 2000);
    chk_period = 1'b0;
    chk("R6 sweep frames received", rx_n, exp_n);
    repeat (20) @(negedge clk);
    rd(2'd1, s);
    chk("R7 done after sweep", s[1], 1);

    // software clear collides with hardware transfer
    wr(2'd0, 8'h81);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h00;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
    push(8'h81, 1'b0);
    rd(2'd1, s);
    chk("R10 empty after collision", s[0], 1);
    repeat (2*176 + 60) @(negedge clk);
    chk("R10 single frame sent", rx_n, exp_n);

    // slow ticks
    tick_div = 3;
    wr(2'd0, 8'h5A);
    wr(2'd1, 8'h04);
    push(8'h5A, 1'b1);
    t0 = cyc;
    wait_rx(exp_n, 1200);
    chk("R12 slow frame received", rx_n, exp_n);
    chk_rng("R12 slow frame duration", cyc - t0, 3*168, 3*176 + 20);
    repeat (80) @(negedge clk);
    tick_div = 1;
    repeat (20) @(negedge clk);

    // abort mid-frame
    dec_on = 1'b0;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    repeat (40) @(negedge clk);
    wr(2'd2, 8'h02);
    rd(2'd1, s);
    chk("R9 flags after disable", s[1:0], 2'b11);
    chk("R9 line after disable", txd, 1);

    // break through port override
    wr(2'd3, 8'h02);
    @(negedge clk);
    chk("R11 override low while disabled", txd, 0);
    wr(2'd2, 8'h01);
    repeat (30) @(negedge clk);
    chk("R11 override low while enabled", txd, 0);
    wr(2'd3, 8'h03);
    @(negedge clk);
    chk("R11 override high", txd, 1);
    wr(2'd3, 8'h00);
    @(negedge clk);
    chk("R11 override released", txd, 1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule